// File: doc/BRIEF.md
# Serial Command Frame CRC Guard

This block sits between the bit shifter of a serial register port and the register file. Received bits arrive one per accepted transfer, most significant bit first. When checking is on, a frame is 32 bits: a 24-bit command payload followed by an 8-bit CRC. The block runs a CRC over all 32 bits. A zero remainder releases the payload as a command. A nonzero remainder drops the command and raises a per-frame error flag. When checking is off, a frame is 24 payload bits and every complete frame is released.

Bad frames advance a saturating error counter. When the count after an increment reaches a programmable limit, a sticky fault is set. The fault stays set until the register file signals a successful read of the alarm status. It drives an active-low alarm unless masked. On the way out, the block appends a CRC over the 24 read-data bits of each readback word.

Commands leave on a valid/ready stream. While a command is held (valid high, ready low), `rx_ready` is low, so the shifter stalls and no bit is lost. The readback path is a combinational valid/ready pass-through: `rd_ready` follows `tx_ready`, and `tx_valid` follows `rd_valid`. Configuration writes are meant to happen between frames.

Top module: `spi_crc_guard`

## Requirements
- R1: After reset, checking is enabled, `cmd_valid` is 0, `frm_crc_err` is 0, `err_cnt` is 0, `crc_fault` is 0 and `alarm_n` is 1.
- R2: With checking enabled, a frame is 32 accepted bits. The first bit received lands in `cmd_data[23]`, and the last 8 bits are the CRC. The CRC uses polynomial x^8+x^2+x+1 (0x07), starts from 0x00, has no final XOR and processes bits MSB first. A frame whose 32-bit remainder is zero raises `cmd_valid` with the payload on the edge that accepts its last bit.
- R3: A checked frame with a nonzero remainder issues no command, and `frm_crc_err` is 1 after its last bit.
- R4: `frm_crc_err` is updated at the end of every complete frame and is not sticky. A good frame returns it to 0.
- R5: With checking disabled (`cfg_crc_en`=0 written via `cfg_we`), a frame is 24 bits and is always issued. `frm_crc_err` is 0 and `err_cnt` does not change.
- R6: Each bad frame increments `err_cnt`. The counter saturates at 2^CNT_W-1.
- R7: `crc_fault` sets when a bad frame brings the count to a value at or above the limit (`cfg_limit`). It then stays set until `stat_clr`.
- R8: A `stat_clr` pulse clears `err_cnt` and `crc_fault`. A bad frame ending in the same cycle is counted after the clear, and the fault can re-latch from it.
- R9: `alarm_n` is 0 exactly when `crc_fault` is 1 and `fault_mask` is 0.
- R10: `tx_frame` is {`rd_data`, CRC of `rd_data`} with checking enabled, and {`rd_data`, 8'h00} with checking disabled.
- R11: A command holds `cmd_valid` and `cmd_data` until `cmd_ready`. While a command is pending, `rx_ready` is 0.
- R12: `csn` high abandons a partial frame. The next frame starts from bit 0 with a fresh CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low async reset |
| cfg_we | input | 1 | write configuration |
| cfg_crc_en | input | 1 | checking enable to write |
| cfg_limit | input | CNT_W | fault threshold to write |
| csn | input | 1 | frame select, high = idle/abort |
| rx_valid | input | 1 | received bit valid |
| rx_bit | input | 1 | received bit |
| rx_ready | output | 1 | bit accepted when high |
| cmd_valid | output | 1 | command available |
| cmd_ready | input | 1 | command taken |
| cmd_data | output | 24 | command payload |
| frm_crc_err | output | 1 | previous frame failed CRC |
| err_cnt | output | CNT_W | saturating bad-frame count |
| crc_fault | output | 1 | sticky CRC fault |
| fault_mask | input | 1 | masks alarm |
| alarm_n | output | 1 | active-low alarm |
| stat_clr | input | 1 | successful alarm status read |
| rd_valid | input | 1 | read data valid |
| rd_ready | output | 1 | read data taken |
| rd_data | input | 24 | read data |
| tx_valid | output | 1 | readback word valid |
| tx_ready | input | 1 | readback word taken |
| tx_frame | output | 32 | read data with CRC |

## Verification
A corrupted CRC register shows on the edge that accepts a frame's last bit. A good frame then fails to issue, or `frm_crc_err` flips. A wrong bit counter shifts frame boundaries, so the next command carries a misaligned payload. A faulty counter or sticky bit shows on `err_cnt`, `crc_fault` and `alarm_n` in the cycle after the offending frame. The bench flips each of the 32 bit positions one at a time, so every single-bit error must be caught, and it sweeps the readback CRC across many words.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int PAY_W  = 24;
  localparam int CRC_W  = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
  endfunction

  function automatic logic [CRC_W-1:0] crc_word(input logic [PAY_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = PAY_W - 1; i >= 0; i--) c = crc_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/spi_crc_rx.sv
module spi_crc_rx
  import spi_crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crc_en,
  input  logic             csn,
  input  logic             rx_valid,
  input  logic             rx_bit,
  output logic             rx_ready,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [PAY_W-1:0] cmd_data,
  output logic             crc_err,
  output logic             frame_bad
);
  localparam int FRM_W = PAY_W + CRC_W;
  localparam int BCW   = $clog2(FRM_W + 1);

  logic [BCW-1:0]   bit_cnt;
  logic [CRC_W-1:0] crc_q, crc_n;
  logic [PAY_W-1:0] sh_q, sh_n;
  logic [BCW-1:0]   last_idx;
  logic             accept, last;

  assign rx_ready  = ~cmd_valid;
  assign accept    = rx_valid & rx_ready & ~csn;
  assign last_idx  = crc_en ? BCW'(FRM_W - 1) : BCW'(PAY_W - 1);
  assign last      = accept & (bit_cnt == last_idx);
  assign crc_n     = crc_step(crc_q, rx_bit);
  assign sh_n      = {sh_q[PAY_W-2:0], rx_bit};
  assign frame_bad = last & crc_en & (crc_n != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      crc_q   <= '0;
      sh_q    <= '0;
    end else if (csn) begin
      bit_cnt <= '0;
      crc_q   <= '0;
    end else if (accept) begin
      if (bit_cnt < BCW'(PAY_W)) sh_q <= sh_n;
      if (last) begin
        bit_cnt <= '0;
        crc_q   <= '0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        crc_q   <= crc_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      crc_err   <= 1'b0;
    end else begin
      if (last) crc_err <= frame_bad;
      if (last && !frame_bad) begin
        cmd_valid <= 1'b1;
        cmd_data  <= crc_en ? sh_q : sh_n;
      end else if (cmd_ready) begin
        cmd_valid <= 1'b0;
      end
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data)); // R11
  AST_BAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> !cmd_valid && crc_err); // R3
  AST_NO_ERR_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
    last && !crc_en |=> !crc_err && cmd_valid); // R5
endmodule

// File: rtl/spi_crc_fault.sv
module spi_crc_fault #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bad,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  input  logic             mask,
  output logic [CNT_W-1:0] cnt,
  output logic             fault,
  output logic             alarm_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] base, cnt_n;
  logic             fault_n;

  always_comb begin
    base    = clr ? '0 : cnt;
    cnt_n   = (bad && base != CNT_MAX) ? base + 1'b1 : base;
    fault_n = (clr ? 1'b0 : fault) | (bad && cnt_n >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      fault <= fault_n;
    end
  end

  assign alarm_n = ~(fault & ~mask);

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_MAX && !clr |=> cnt == CNT_MAX); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !clr |=> fault); // R7
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(bad)); // R7
  AST_CLR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !bad |=> cnt == '0 && !fault); // R8
endmodule

// File: rtl/spi_crc_tx.sv
module spi_crc_tx
  import spi_crc_pkg::*;
(
  input  logic                   crc_en,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [PAY_W-1:0]       rd_data,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [PAY_W+CRC_W-1:0] tx_frame
);
  assign tx_valid = rd_valid;
  assign rd_ready = tx_ready;
  assign tx_frame = {rd_data, crc_en ? crc_word(rd_data) : {CRC_W{1'b0}}};
endmodule

// File: rtl/spi_crc_guard.sv
module spi_crc_guard
  import spi_crc_pkg::*;
#(
  parameter int               CNT_W     = 4,
  parameter logic [CNT_W-1:0] LIMIT_RST = CNT_W'(8)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_crc_en,
  input  logic [CNT_W-1:0]       cfg_limit,
  input  logic                   csn,
  input  logic                   rx_valid,
  input  logic                   rx_bit,
  output logic                   rx_ready,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [PAY_W-1:0]       cmd_data,
  output logic                   frm_crc_err,
  output logic [CNT_W-1:0]       err_cnt,
  output logic                   crc_fault,
  input  logic                   fault_mask,
  output logic                   alarm_n,
  input  logic                   stat_clr,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [PAY_W-1:0]       rd_data,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [PAY_W+CRC_W-1:0] tx_frame
);
  logic             crc_en_q;
  logic [CNT_W-1:0] limit_q;
  logic             frame_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_en_q <= 1'b1;
      limit_q  <= LIMIT_RST;
    end else if (cfg_we) begin
      crc_en_q <= cfg_crc_en;
      limit_q  <= cfg_limit;
    end
  end

  spi_crc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en_q), .csn(csn),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_ready(rx_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .crc_err(frm_crc_err), .frame_bad(frame_bad)
  );

  spi_crc_fault #(.CNT_W(CNT_W)) u_fault (
    .clk(clk), .rst_n(rst_n), .bad(frame_bad), .clr(stat_clr),
    .limit(limit_q), .mask(fault_mask), .cnt(err_cnt),
    .fault(crc_fault), .alarm_n(alarm_n)
  );

  spi_crc_tx u_tx (
    .crc_en(crc_en_q), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_frame(tx_frame)
  );

  AST_ALARM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_n |-> crc_fault && !fault_mask); // R9
endmodule

// File: tb/sim_spi_crc_guard.sv
module sim_spi_crc_guard;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_crc_en = 1;
  logic [3:0] cfg_limit = 0;
  logic csn = 1, rx_valid = 0, rx_bit = 0, cmd_ready = 0;
  logic fault_mask = 0, stat_clr = 0;
  logic rd_valid = 0, tx_ready = 0;
  logic [23:0] rd_data = 0;
  logic rx_ready, cmd_valid, frm_crc_err, crc_fault, alarm_n, rd_ready, tx_valid;
  logic [23:0] cmd_data;
  logic [3:0] err_cnt;
  logic [31:0] tx_frame;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  spi_crc_guard u0 (.*);

  function automatic logic [7:0] ref_crc(input logic [23:0] d);
    logic [31:0] r;
    r = {d, 8'h00};
    for (int i = 31; i >= 8; i--) if (r[i]) r = r ^ (32'h107 << (i - 8));
    return r[7:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input int nbits, input bit clr_last);
    @(negedge clk); csn = 0;
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk);
      rx_valid = 1; rx_bit = w[i];
      stat_clr = (i == 0) && clr_last;
    end
    @(negedge clk); rx_valid = 0; stat_clr = 0;
  endtask

  task automatic ack();
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
  endtask

  task automatic cfg(input logic en, input logic [3:0] lim);
    @(negedge clk); cfg_we = 1; cfg_crc_en = en; cfg_limit = lim;
    @(negedge clk); cfg_we = 0;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] pays [5];
    int exp_cnt;
    pays = '{24'h000000, 24'hFFFFFF, 24'hA5A5A5, 24'h123456, 24'h800001};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 err", frm_crc_err, 0);
    chk("R1 cnt", err_cnt, 0);
    chk("R1 fault", crc_fault, 0);
    chk("R1 alarm_n", alarm_n, 1);

    // R2 good frames with checking on by default
    foreach (pays[k]) begin
      send({pays[k], ref_crc(pays[k])}, 32, 0);
      chk("R2 cmd_valid", cmd_valid, 1);
      chk("R2 cmd_data", cmd_data, pays[k]);
      chk("R4 err clear", frm_crc_err, 0);
      chk("R11 stall", rx_ready, 0);
      @(negedge clk);
      chk("R11 hold", {cmd_valid, cmd_data}, {1'b1, pays[k]});
      ack();
      chk("R11 released", {cmd_valid, rx_ready}, 2'b01);
    end

    // R3/R6/R7 single-bit flips at every position, limit 3
    cfg(1, 4'd3);
    exp_cnt = 0;
    for (int p = 0; p < 32; p++) begin
      logic [31:0] w;
      w = {24'h3C5A96, ref_crc(24'h3C5A96)} ^ (32'h1 << p);
      send(w, 32, 0);
      exp_cnt = (exp_cnt < 15) ? exp_cnt + 1 : 15;
      chk("R3 no cmd", cmd_valid, 0);
      chk("R3 err", frm_crc_err, 1);
      chk("R6 cnt", err_cnt, exp_cnt);
      chk("R7 fault", crc_fault, exp_cnt >= 3);
      chk("R9 alarm", alarm_n, !(exp_cnt >= 3));
    end
    fault_mask = 1; @(negedge clk);
    chk("R9 masked", alarm_n, 1);
    fault_mask = 0; @(negedge clk);

    send({24'h0F0F0F, ref_crc(24'h0F0F0F)}, 32, 0);
    chk("R4 nonsticky", frm_crc_err, 0);
    chk("R7 sticky", crc_fault, 1);
    chk("R6 cnt kept", err_cnt, 15);
    ack();

    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0;
    chk("R8 cnt clr", err_cnt, 0);
    chk("R8 fault clr", crc_fault, 0);
    chk("R9 alarm idle", alarm_n, 1);

    // R8 clear coinciding with a bad frame end
    cfg(1, 4'd1);
    send(32'hDEAD_BE00, 32, 0);
    send(32'hDEAD_BE00, 32, 0);
    chk("R8 pre cnt", err_cnt, 2);
    send(32'h1234_5600, 32, 1);
    chk("R8 recount", err_cnt, 1);
    chk("R8 relatch", crc_fault, 1);
    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0;

    // R12 abort mid-frame
    send(32'h0000_03FF, 10, 0);
    @(negedge clk); csn = 1; @(negedge clk);
    send({24'hC0FFEE, ref_crc(24'hC0FFEE)}, 32, 0);
    chk("R12 realign", {cmd_valid, cmd_data}, {1'b1, 24'hC0FFEE});
    chk("R12 err", frm_crc_err, 0);
    ack();

    // R10 readback sweep, checking on
    tx_ready = 1; rd_valid = 1;
    for (int v = 0; v < 300; v++) begin
      rd_data = 24'(v * 56923 + 7);
      #1;
      chk("R10 tx crc", tx_frame, {rd_data, ref_crc(rd_data)});
    end
    chk("R10 handshake", {tx_valid, rd_ready}, 2'b11);

    // R5 checking off: 24-bit frames
    cfg(0, 4'd1);
    send({8'h00, 24'hBADBAD}, 24, 0);
    chk("R5 cmd", {cmd_valid, cmd_data}, {1'b1, 24'hBADBAD});
    chk("R5 err", frm_crc_err, 0);
    chk("R5 cnt", err_cnt, 0);
    ack();
    rd_data = 24'h13579B; #1;
    chk("R10 tx off", tx_frame, {24'h13579B, 8'h00});
    tx_ready = 0; rd_valid = 0; #1;
    chk("R10 handshake off", {tx_valid, rd_ready}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule